// File: doc/BRIEF.md
# Neighbor Disturb Memory Self-Test Engine

This block is a built-in self-test engine for a one-bit-wide memory that is arranged as a grid of rows and columns. It looks for faults where writing one cell disturbs the cells right next to it. For each target cell it writes zero to the target and to its row and column neighbours. It then writes a one into the target again and again. After each of those writes it reads back the target and every neighbour. A target should read one and a neighbour should read zero.

Target cells are picked by a maximal-length LFSR that is seeded when a run starts, so a run covers cells spread across the whole array. The number of targets is set per run. The engine stops at the first mismatch. It then holds the failing address, the bit it expected and the bit the memory actually returned. These values come from the original read and are not re-read. It drives a simple synchronous single-bit memory port whose read data returns one cycle after the request.

Top module: `nd_bist_top`

## Requirements
- R1: After reset, and whenever the engine is not running, busy_o, done_o and fail_o are low (done_o and fail_o are low until the first run ends) and mem_req_o is low. A start_i pulse while busy_o is high is ignored.
- R2: The target address is {row, col}, with row in the upper ROW_W bits. The first target equals seed_i, and a zero seed is replaced by 1. With the default 6+6 bit geometry, the next target is {s[10:0], s[11]^s[5]^s[3]^s[0]}.
- R3: For each target the clear phase writes 0 to these cells, in this order: the target, col+1, col-1, row+1, row-1. Only one access is made per cycle.
- R4: A neighbour that lies outside the array is never accessed. Addresses do not wrap around.
- R5: After the clear phase, the engine does the following REPEAT times: it writes 1 to the target, then reads the target and each neighbour that exists, in the same order as in R3.
- R6: Read data is compared on the cycle after the read request. The target must read 1 and each neighbour must read 0.
- R7: On the first mismatch, fail_o rises and no further memory access is made. err_row_o, err_col_o, err_exp_o and err_got_o show the failing address, the expected bit and the bit that was returned. They hold until the next start.
- R8: After num_targets_i targets pass, done_o goes high and stays high until the next start. A count of zero sets done_o with no memory access.
- R9: From the cycle after an accepted start until done or fail, busy_o is high. done_o and fail_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run; loads seed and target count |
| seed_i | input | ROW_W+COL_W | LFSR seed; also the first target address |
| num_targets_i | input | TGT_W | Number of targets to test |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished with no mismatch |
| fail_o | output | 1 | Run stopped on a mismatch |
| err_row_o | output | ROW_W | Row of the failing cell |
| err_col_o | output | COL_W | Column of the failing cell |
| err_exp_o | output | 1 | Expected bit at the failure |
| err_got_o | output | 1 | Bit the memory returned |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_row_o | output | ROW_W | Memory row address |
| mem_col_o | output | COL_W | Memory column address |
| mem_wdata_o | output | 1 | Write data |
| mem_rdata_i | input | 1 | Read data, valid the cycle after a read request |

## Verification
The bench records every memory access and compares it entry by entry with a sequence it derives on its own from the LFSR rule and the neighbour order. It uses seeds that put the target in corners and at the zero-seed substitute. A design that wrapped addresses at an edge, or that issued an access for a missing neighbour, would add entries to the log that should not be there. The bench's memory model also injects two faults in the middle of a run. In the first, a neighbour is set to 1 during a chosen repetition and then heals right after it is read. In the second, a single write of 1 to the target is lost. An engine that re-read the cell to build its report, or that kept running after the mismatch, would show a wrong captured bit or extra accesses. A start pulse during a run and a run with a count of zero check the edges of the control logic.

// File: rtl/nd_pkg.sv
package nd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_WR1, ST_READ, ST_DRAIN, ST_DONE, ST_FAIL
  } state_e;

  // visiting order of the five cells; slot 0 is the target
  localparam logic [2:0] SLOT_TGT  = 3'd0;
  localparam logic [2:0] SLOT_CINC = 3'd1;
  localparam logic [2:0] SLOT_CDEC = 3'd2;
  localparam logic [2:0] SLOT_RINC = 3'd3;
  localparam logic [2:0] SLOT_RDEC = 3'd4;
  localparam logic [2:0] SLOT_LAST = SLOT_RDEC;

  // Fibonacci feedback masks (bit i = tap i+1) for maximal-length sequences
  function automatic logic [31:0] lfsr_mask(input int unsigned w);
    case (w)
      4:       return 32'h0000_000C;
      5:       return 32'h0000_0014;
      6:       return 32'h0000_0030;
      7:       return 32'h0000_0060;
      8:       return 32'h0000_00B8;
      9:       return 32'h0000_0110;
      10:      return 32'h0000_0240;
      11:      return 32'h0000_0500;
      12:      return 32'h0000_0829;
      13:      return 32'h0000_100D;
      14:      return 32'h0000_2015;
      15:      return 32'h0000_6000;
      16:      return 32'h0000_D008;
      default: return 32'h0000_0829;
    endcase
  endfunction

endpackage

// File: rtl/nd_lfsr.sv
module nd_lfsr #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  import nd_pkg::*;

  localparam logic [31:0]  MASK_ALL = lfsr_mask(W);
  localparam logic [W-1:0] MASK     = MASK_ALL[W-1:0];
  localparam logic [W-1:0] ONE      = W'(1);

  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= ONE;
    else if (load_i)  state_q <= (seed_i == '0) ? ONE : seed_i;
    else if (step_i)  state_q <= {state_q[W-2:0], fb};
  end

  assign state_o = state_q;
endmodule

// File: rtl/nd_addr_gen.sv
module nd_addr_gen #(
  parameter int unsigned ROW_W = 6,
  parameter int unsigned COL_W = 6
) (
  input  logic [ROW_W-1:0] tgt_row_i,
  input  logic [COL_W-1:0] tgt_col_i,
  input  logic [2:0]       slot_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o
);
  import nd_pkg::*;

  localparam logic [ROW_W-1:0] ROW_MAX = '1;
  localparam logic [COL_W-1:0] COL_MAX = '1;
  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);
  localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);

  always_comb begin
    row_o   = tgt_row_i;
    col_o   = tgt_col_i;
    valid_o = 1'b1;
    unique case (slot_i)
      SLOT_TGT: ;
      SLOT_CINC: begin
        col_o   = tgt_col_i + COL_ONE;
        valid_o = (tgt_col_i != COL_MAX);
      end
      SLOT_CDEC: begin
        col_o   = tgt_col_i - COL_ONE;
        valid_o = (tgt_col_i != '0);
      end
      SLOT_RINC: begin
        row_o   = tgt_row_i + ROW_ONE;
        valid_o = (tgt_row_i != ROW_MAX);
      end
      SLOT_RDEC: begin
        row_o   = tgt_row_i - ROW_ONE;
        valid_o = (tgt_row_i != '0);
      end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nd_cmp.sv
module nd_cmp #(
  parameter int unsigned ROW_W = 6,
  parameter int unsigned COL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             issue_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             exp_i,
  input  logic             rdata_i,
  output logic             mismatch_o,
  output logic [ROW_W-1:0] err_row_o,
  output logic [COL_W-1:0] err_col_o,
  output logic             err_exp_o,
  output logic             err_got_o
);
  logic             pend_v_q;
  logic [ROW_W-1:0] pend_row_q;
  logic [COL_W-1:0] pend_col_q;
  logic             pend_exp_q;

  assign mismatch_o = pend_v_q && (rdata_i != pend_exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q   <= 1'b0;
      pend_row_q <= '0;
      pend_col_q <= '0;
      pend_exp_q <= 1'b0;
    end else if (clear_i) begin
      pend_v_q <= 1'b0;
    end else begin
      pend_v_q <= issue_i;
      if (issue_i) begin
        pend_row_q <= row_i;
        pend_col_q <= col_i;
        pend_exp_q <= exp_i;
      end
    end
  end

  // capture the sampled bit; the cell is never read again for the report
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_row_o <= '0;
      err_col_o <= '0;
      err_exp_o <= 1'b0;
      err_got_o <= 1'b0;
    end else if (clear_i) begin
      err_row_o <= '0;
      err_col_o <= '0;
      err_exp_o <= 1'b0;
      err_got_o <= 1'b0;
    end else if (mismatch_o) begin
      err_row_o <= pend_row_q;
      err_col_o <= pend_col_q;
      err_exp_o <= pend_exp_q;
      err_got_o <= rdata_i;
    end
  end
endmodule

// File: rtl/nd_seq.sv
module nd_seq #(
  parameter int unsigned TGT_W  = 20,
  parameter int unsigned REPEAT = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TGT_W-1:0] num_targets_i,
  input  logic             slot_valid_i,
  input  logic             mismatch_i,
  output logic [2:0]       slot_o,
  output logic             acc_req_o,
  output logic             acc_we_o,
  output logic             acc_wdata_o,
  output logic             issue_o,
  output logic             start_ok_o,
  output logic             lfsr_step_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);
  import nd_pkg::*;

  localparam int unsigned    REP_W    = $clog2(REPEAT + 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEAT - 1);
  localparam logic [TGT_W-1:0] TGT_ONE  = TGT_W'(1);

  state_e           state_q, state_d;
  logic [2:0]       slot_q, slot_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic [TGT_W-1:0] left_q, left_d;
  logic             idle;

  assign idle = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);

  always_comb begin
    state_d     = state_q;
    slot_d      = slot_q;
    rep_d       = rep_q;
    left_d      = left_q;
    acc_req_o   = 1'b0;
    acc_we_o    = 1'b0;
    acc_wdata_o = 1'b0;
    issue_o     = 1'b0;
    start_ok_o  = 1'b0;
    lfsr_step_o = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start_i) begin
          start_ok_o = 1'b1;
          left_d     = num_targets_i;
          slot_d     = SLOT_TGT;
          rep_d      = '0;
          state_d    = (num_targets_i == '0) ? ST_DONE : ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        acc_req_o = slot_valid_i;
        acc_we_o  = 1'b1;
        if (slot_q == SLOT_LAST) begin
          slot_d  = SLOT_TGT;
          state_d = ST_WR1;
        end else begin
          slot_d = slot_q + 3'd1;
        end
      end
      ST_WR1: begin
        acc_req_o   = 1'b1;
        acc_we_o    = 1'b1;
        acc_wdata_o = 1'b1;
        state_d     = ST_READ;
      end
      ST_READ: begin
        acc_req_o = slot_valid_i;
        issue_o   = slot_valid_i;
        if (slot_q == SLOT_LAST) begin
          slot_d = SLOT_TGT;
          if (rep_q == REP_LAST) begin
            rep_d = '0;
            if (left_q == TGT_ONE) begin
              state_d = ST_DRAIN;
            end else begin
              left_d      = left_q - TGT_ONE;
              lfsr_step_o = 1'b1;
              state_d     = ST_CLEAR;
            end
          end else begin
            rep_d   = rep_q + REP_W'(1);
            state_d = ST_WR1;
          end
        end else begin
          slot_d = slot_q + 3'd1;
        end
      end
      ST_DRAIN: state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
    // a mismatch freezes everything in the cycle it is seen
    if (mismatch_i) begin
      acc_req_o   = 1'b0;
      issue_o     = 1'b0;
      lfsr_step_o = 1'b0;
      state_d     = ST_FAIL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= SLOT_TGT;
      rep_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      rep_q   <= rep_d;
      left_q  <= left_d;
    end
  end

  assign slot_o = slot_q;
  assign busy_o = !idle;
  assign done_o = (state_q == ST_DONE);
  assign fail_o = (state_q == ST_FAIL);
endmodule

// File: rtl/nd_bist_top.sv
module nd_bist_top #(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned COL_W  = 6,
  parameter int unsigned TGT_W  = 20,
  parameter int unsigned REPEAT = 100
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [ROW_W+COL_W-1:0] seed_i,
  input  logic [TGT_W-1:0]       num_targets_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   fail_o,
  output logic [ROW_W-1:0]       err_row_o,
  output logic [COL_W-1:0]       err_col_o,
  output logic                   err_exp_o,
  output logic                   err_got_o,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [ROW_W-1:0]       mem_row_o,
  output logic [COL_W-1:0]       mem_col_o,
  output logic                   mem_wdata_o,
  input  logic                   mem_rdata_i
);
  import nd_pkg::*;

  localparam int unsigned AW = ROW_W + COL_W;

  logic [AW-1:0]    tgt;
  logic [2:0]       slot;
  logic             slot_valid, mismatch, issue, start_ok, lfsr_step;
  logic [ROW_W-1:0] cell_row;
  logic [COL_W-1:0] cell_col;

  nd_lfsr #(.W(AW)) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ok),
    .seed_i  (seed_i),
    .step_i  (lfsr_step),
    .state_o (tgt)
  );

  nd_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) i_addr_gen (
    .tgt_row_i (tgt[AW-1:COL_W]),
    .tgt_col_i (tgt[COL_W-1:0]),
    .slot_i    (slot),
    .row_o     (cell_row),
    .col_o     (cell_col),
    .valid_o   (slot_valid)
  );

  nd_seq #(.TGT_W(TGT_W), .REPEAT(REPEAT)) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .num_targets_i (num_targets_i),
    .slot_valid_i  (slot_valid),
    .mismatch_i    (mismatch),
    .slot_o        (slot),
    .acc_req_o     (mem_req_o),
    .acc_we_o      (mem_we_o),
    .acc_wdata_o   (mem_wdata_o),
    .issue_o       (issue),
    .start_ok_o    (start_ok),
    .lfsr_step_o   (lfsr_step),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .fail_o        (fail_o)
  );

  nd_cmp #(.ROW_W(ROW_W), .COL_W(COL_W)) i_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_ok),
    .issue_i    (issue),
    .row_i      (cell_row),
    .col_i      (cell_col),
    .exp_i      (slot == SLOT_TGT),
    .rdata_i    (mem_rdata_i),
    .mismatch_o (mismatch),
    .err_row_o  (err_row_o),
    .err_col_o  (err_col_o),
    .err_exp_o  (err_exp_o),
    .err_got_o  (err_got_o)
  );

  assign mem_row_o = cell_row;
  assign mem_col_o = cell_col;
endmodule

// File: rtl/nd_bist_chk.sv
module nd_bist_chk #(
  parameter int unsigned ROW_W = 6,
  parameter int unsigned COL_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             fail_o,
  input logic [ROW_W-1:0] err_row_o,
  input logic [COL_W-1:0] err_col_o,
  input logic             err_exp_o,
  input logic             err_got_o,
  input logic             mem_req_o
);
  a_r1_idle_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  a_r9_done_fail_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  a_r9_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o || done_o));

  a_r7_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> (fail_o && $stable({err_row_o, err_col_o, err_exp_o, err_got_o})));

  a_r8_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

bind nd_bist_top nd_bist_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) i_nd_bist_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .err_row_o (err_row_o),
  .err_col_o (err_col_o),
  .err_exp_o (err_exp_o),
  .err_got_o (err_got_o),
  .mem_req_o (mem_req_o)
);

// File: tb/test_nd_bist_top.sv
module test_nd_bist_top;
  localparam int ROW_W  = 6;
  localparam int COL_W  = 6;
  localparam int TGT_W  = 20;
  localparam int REPEAT = 8;
  localparam int AW     = ROW_W + COL_W;
  localparam int CELLS  = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic             start_i = 1'b0;
  logic [AW-1:0]    seed_i = '0;
  logic [TGT_W-1:0] num_targets_i = '0;
  logic             busy_o, done_o, fail_o, err_exp_o, err_got_o;
  logic [ROW_W-1:0] err_row_o, mem_row_o;
  logic [COL_W-1:0] err_col_o, mem_col_o;
  logic             mem_req_o, mem_we_o, mem_wdata_o;
  logic             mem_rdata_i = 1'b0;

  nd_bist_top #(.ROW_W(ROW_W), .COL_W(COL_W), .TGT_W(TGT_W), .REPEAT(REPEAT)) i_nd_bist_top (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .seed_i(seed_i),
    .num_targets_i(num_targets_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .err_row_o(err_row_o), .err_col_o(err_col_o), .err_exp_o(err_exp_o),
    .err_got_o(err_got_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_row_o(mem_row_o), .mem_col_o(mem_col_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  int unsigned n_cmp = 0, n_bad = 0;

  // memory model with fault injection; log entry = {we, wdata, addr}
  logic          mem [CELLS];
  logic [AW+1:0] log_q [$];
  logic [AW+1:0] exp_q [$];
  logic          inj_on = 1'b0, inj_stuck = 1'b0, inj_armed = 1'b0;
  logic [AW-1:0] inj_tgt = '0, inj_vic = '0;
  int            inj_k = 0, wr1_cnt = 0;

  always @(posedge clk) begin : mem_model
    logic [AW-1:0] a;
    a = {mem_row_o, mem_col_o};
    if (mem_req_o) begin
      log_q.push_back({mem_we_o, mem_wdata_o, a});
      if (mem_we_o) begin
        if (inj_on && a == inj_tgt && mem_wdata_o) begin
          wr1_cnt = wr1_cnt + 1;
          if (wr1_cnt == inj_k) begin
            if (inj_stuck) mem[a] <= 1'b0;
            else begin
              mem[a] <= 1'b1;
              mem[inj_vic] <= 1'b1;
              inj_armed = 1'b1;
            end
          end else mem[a] <= 1'b1;
        end else mem[a] <= mem_wdata_o;
      end else begin
        mem_rdata_i <= mem[a];
        if (inj_armed && a == inj_vic) begin
          mem[a] <= 1'b0;  // heals: a re-read would see 0
          inj_armed = 1'b0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [AW-1:0] lfsr_nx(input logic [AW-1:0] s);
    return {s[AW-2:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
  endfunction

  function automatic logic [AW-1:0] tgt_of(input logic [AW-1:0] seed, input int idx);
    logic [AW-1:0] t = (seed == '0) ? AW'(1) : seed;
    for (int i = 0; i < idx; i++) t = lfsr_nx(t);
    return t;
  endfunction

  function automatic bit nb_ok(input logic [AW-1:0] t, input int k);
    logic [ROW_W-1:0] r = t[AW-1:COL_W];
    logic [COL_W-1:0] c = t[COL_W-1:0];
    case (k)
      0: return 1'b1;
      1: return c != '1;
      2: return c != '0;
      3: return r != '1;
      default: return r != '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] nb_addr(input logic [AW-1:0] t, input int k);
    logic [ROW_W-1:0] r = t[AW-1:COL_W];
    logic [COL_W-1:0] c = t[COL_W-1:0];
    case (k)
      1: c = c + 1'b1;
      2: c = c - 1'b1;
      3: r = r + 1'b1;
      4: r = r - 1'b1;
      default: ;
    endcase
    return {r, c};
  endfunction

  task automatic build_exp(input logic [AW-1:0] seed, input int n, input int f_ti,
                           input int f_rep, input int f_slot, output int fail_idx);
    logic [AW-1:0] t = (seed == '0) ? AW'(1) : seed;
    exp_q.delete();
    fail_idx = -1;
    for (int ti = 0; ti < n; ti++) begin
      for (int k = 0; k < 5; k++)
        if (nb_ok(t, k)) exp_q.push_back({1'b1, 1'b0, nb_addr(t, k)});
      for (int r = 0; r < REPEAT; r++) begin
        exp_q.push_back({1'b1, 1'b1, t});
        for (int k = 0; k < 5; k++)
          if (nb_ok(t, k)) begin
            exp_q.push_back({1'b0, 1'b0, nb_addr(t, k)});
            if (ti == f_ti && r == f_rep && k == f_slot && fail_idx < 0)
              fail_idx = exp_q.size() - 1;
          end
      end
      t = lfsr_nx(t);
    end
  endtask

  // f_ti < 0: clean run; poke: extra start pulse while busy (R1)
  task automatic run(input logic [AW-1:0] seed, input int n, input int f_ti, input int f_rep,
                     input int f_slot, input bit stuck, input bit poke, input string tag);
    int fail_idx, lim, first_bad;
    logic [AW-1:0] ftgt;
    build_exp(seed, n, f_ti, f_rep, f_slot, fail_idx);
    ftgt = tgt_of(seed, (f_ti < 0) ? 0 : f_ti);
    log_q.delete();
    inj_on = (f_ti >= 0); inj_stuck = stuck; inj_armed = 1'b0;
    inj_tgt = ftgt; inj_vic = nb_addr(ftgt, f_slot); inj_k = f_rep + 1; wr1_cnt = 0;
    @(negedge clk);
    seed_i = seed; num_targets_i = TGT_W'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o || (n == 0 && done_o), "R9", {tag, " busy after start"}, busy_o, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      seed_i = seed ^ AW'(5); num_targets_i = TGT_W'(1); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    lim = n * (5 + REPEAT * 6) + 100;
    for (int i = 0; i < lim && !(done_o || fail_o); i++) @(negedge clk);
    check(!busy_o, "R9", {tag, " idle at end"}, busy_o, 0);
    check(!(done_o && fail_o), "R9", {tag, " done/fail exclusive"}, {done_o, fail_o}, 0);
    if (n > 0 && log_q.size() > 0)
      check(log_q[0] == {2'b10, tgt_of(seed, 0)}, "R2", {tag, " first access at seed target"},
            log_q[0], {2'b10, tgt_of(seed, 0)});
    if (fail_idx >= 0) exp_q = exp_q[0:fail_idx];
    first_bad = -1;
    for (int i = 0; i < log_q.size() && i < exp_q.size(); i++)
      if (first_bad < 0 && log_q[i] != exp_q[i]) first_bad = i;
    check(first_bad < 0, "R3 R4 R5", {tag, " access sequence index"}, first_bad, -1);
    check(log_q.size() == exp_q.size(), (fail_idx >= 0) ? "R7" : "R5",
          {tag, " access count"}, log_q.size(), exp_q.size());
    if (fail_idx < 0) begin
      check(done_o && !fail_o, (n == 0) ? "R8 count zero" : "R8", {tag, " done"}, done_o, 1);
    end else begin
      check(fail_o && !done_o, "R6", {tag, " fail raised"}, fail_o, 1);
      check({err_row_o, err_col_o} == inj_vic, "R7", {tag, " err address"},
            {err_row_o, err_col_o}, inj_vic);
      check(err_exp_o == (f_slot == 0), "R6", {tag, " err expected bit"}, err_exp_o, f_slot == 0);
      check(err_got_o == (f_slot != 0), "R7", {tag, " err read bit"}, err_got_o, f_slot != 0);
    end
    begin
      int sz = log_q.size();
      logic [AW+1:0] snap = {err_exp_o, err_got_o, err_row_o, err_col_o};
      repeat (10) @(negedge clk);
      check(log_q.size() == sz, "R7", {tag, " no access after end"}, log_q.size(), sz);
      check({err_exp_o, err_got_o, err_row_o, err_col_o} == snap && (done_o || fail_o),
            "R7 R8", {tag, " result held"}, {err_exp_o, err_got_o, err_row_o, err_col_o}, snap);
    end
    inj_on = 1'b0;
  endtask

  initial begin : watchdog
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int s;
    void'($urandom(32'd4242));
    for (int i = 0; i < CELLS; i++) mem[i] = 1'($urandom);
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !fail_o && !mem_req_o, "R1", "reset state",
          {busy_o, done_o, fail_o, mem_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && !mem_req_o, "R1", "idle after reset", {busy_o, mem_req_o}, 0);

    run(12'hFFF, 3, -1, 0, 0, 0, 0, "corner max R4");
    run(12'h000, 2, -1, 0, 0, 0, 0, "zero seed R2");
    run(12'h03F, 2, -1, 0, 0, 0, 0, "top right R4");
    run(12'h840, 0, -1, 0, 0, 0, 0, "count zero R8");
    run(12'($urandom), 12, -1, 0, 0, 0, 1, "start while busy R1");
    for (int i = 0; i < 3; i++) run(12'($urandom), 1 + $urandom_range(0, 9), -1, 0, 0, 0, 0, "random");

    // neighbour disturbed to 1 during repetition 3 of target 2
    begin
      logic [AW-1:0] sd = 12'($urandom);
      logic [AW-1:0] t2 = tgt_of(sd, 2);
      s = 1 + $urandom_range(0, 3);
      while (!nb_ok(t2, s)) s = (s % 4) + 1;
      run(sd, 4, 2, 3, s, 0, 0, "neighbour disturb R6");
    end
    // lost write of 1 on target 1, first repetition
    run(12'($urandom), 3, 1, 0, 0, 1, 0, "target loss R6");
    // clean restart after a failure clears fail and error capture
    run(12'h5A5, 2, -1, 0, 0, 0, 0, "restart after fail R7");
    check(err_got_o == 1'b0 && err_exp_o == 1'b0, "R7", "error cleared by start",
          {err_exp_o, err_got_o}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule